// File: doc/BRIEF.md
# Ping-Pong Bulk Receive Buffer Controller

This block holds the receive data for one bulk or interrupt OUT endpoint in two packet buffers. While the bus side fills one buffer, the CPU or a DMA engine reads the packet that arrived earlier from the other buffer. The bus side marks each data packet with a start strobe and byte-write strobes. It closes the packet with an end strobe that carries a good or bad flag. The block answers each good packet with a one-cycle ACK or NAK pulse.

The read side sees a ready flag, the byte count of the packet at its head, a byte read port with an advance strobe, a clear strobe that hands a buffer back, and a DMA request. When both buffers hold unread packets, the next OUT is refused. A clear issued while the other buffer holds a finished packet keeps the ready flag set and moves the read side to that packet.

Top module: `pp_rx_top`

## Requirements
- R1: After a synchronous reset, `rx_ready`, `rx_count`, `dma_req`, `ack`, `nak` and `rd_data` are all 0.
- R2: A good packet stored into a free buffer produces `ack`=1 (and `nak`=0) in the cycle after the clock edge that samples `pkt_end`. The packet then becomes readable with `rx_count` equal to its byte count.
- R3: When both buffers hold unread packets at `pkt_start`, the packet is refused. A good end then produces `nak`=1 and `ack`=0. Nothing is stored, and the packet at the read side keeps its count and data.
- R4: A packet ending with `pkt_good`=0 produces neither `ack` nor `nak`. Its buffer stays free, so `rx_ready` does not rise and the next good packet is accepted.
- R5: A clear while the other buffer holds a complete packet leaves `rx_ready` at 1. `rx_count` and `rd_data` switch at once to that packet, starting at its first byte.
- R6: A clear while the other buffer holds no complete packet drops `rx_ready`. A packet still being received then raises `rx_ready` when it completes.
- R7: `rd_data` shows the byte at the current read position of the head packet, and each `rd_en` advances to the next byte. Bytes appear in write order.
- R8: `dma_req` is 1 exactly while the head packet has unread bytes, and drops after its last byte is read.
- R9: With no unread byte, `rd_data` is 0 and `rd_en` changes nothing. The same holds for `clr_ready` when `rx_ready` is 0.
- R10: Bytes written past the buffer depth (64 by default) are dropped, and the count saturates at the depth.
- R11: Packets are read in arrival order. After a refusal, a clear frees a buffer that accepts the next packet, and that packet is read after the one already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_start | input | 1 | Start of an OUT data packet |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DW | Byte to store |
| pkt_end | input | 1 | End of the current packet |
| pkt_good | input | 1 | Packet integrity flag, sampled with `pkt_end` |
| ack | output | 1 | Packet accepted (one-cycle pulse) |
| nak | output | 1 | Packet refused (one-cycle pulse) |
| rd_en | input | 1 | Advance to the next byte of the head packet |
| rd_data | output | DW | Byte at the current read position |
| rx_count | output | CW | Byte count of the head packet, 0 when none |
| rx_ready | output | 1 | A received packet is at the read side |
| clr_ready | input | 1 | Software done with the head packet |
| dma_req | output | 1 | Unread bytes remain in the head packet |

## Verification
The hardest situation to reach is a clear that lands while both buffers hold finished packets. It takes two accepted packets, then a third packet that must be refused, and only then the clear that should keep the ready flag and switch the read side. A directed task builds this sequence. It checks the NAK and the untouched head packet, and after the clear it checks the second packet's count and first byte. It then sends a further packet into the freed buffer to confirm arrival order. A second task clears the ready flag while a packet is half written, which covers the case where the read side waits with no data.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;
  // Choose the read buffer after a packet commits into buffer fill_sel.
  // head_busy: the current (post-clear) read buffer still holds a packet.
  function automatic logic pick_read_sel(input logic head_busy,
                                         input logic head_sel,
                                         input logic fill_sel);
    if (!head_busy || head_sel == fill_sel) return fill_sel;
    return head_sel;
  endfunction

  // Bytes still unread in the head packet.
  function automatic int unsigned bytes_left(input int unsigned count,
                                             input int unsigned pos);
    return (pos < count) ? count - pos : 0;
  endfunction
endpackage

// File: rtl/pp_rx_bank.sv
module pp_rx_bank #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          commit,
  input  logic [CW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wr_idx;
  logic          room;

  assign room  = wr_idx < CW'(DEPTH);
  assign rdata = (raddr < CW'(DEPTH)) ? mem[raddr[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (we && room && !start) mem[wr_idx[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      cnt    <= '0;
    end else begin
      if (start)           wr_idx <= '0;
      else if (we && room) wr_idx <= wr_idx + CW'(1);
      if (commit)          cnt <= wr_idx;
    end
  end

  // R10: the write position never passes the depth
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    wr_idx <= CW'(DEPTH));
endmodule

// File: rtl/pp_rx_ctrl.sv
module pp_rx_ctrl
  import pp_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pkt_start,
  input  logic          pkt_end,
  input  logic          pkt_good,
  input  logic          rd_en,
  input  logic          clr_ready,
  input  logic [CW-1:0] cnt0,
  input  logic [CW-1:0] cnt1,
  output logic          fill_sel,
  output logic          rd_sel,
  output logic [CW-1:0] rd_idx,
  output logic          accepting,
  output logic [1:0]    bank_start,
  output logic [1:0]    bank_commit,
  output logic          ack,
  output logic          nak,
  output logic          rx_ready,
  output logic          rd_valid
);
  logic [1:0]    full, full_c, full_n;
  logic          refusing, both_full, start_ok, done;
  logic          clr_hit, rd_step, other_full;
  logic          rsel_c, rsel_n;
  logic [CW-1:0] cnt_rd;

  assign both_full  = &full;
  assign start_ok   = pkt_start && !both_full;
  assign done       = pkt_end && pkt_good && accepting;
  assign cnt_rd     = rd_sel ? cnt1 : cnt0;
  assign rx_ready   = full[rd_sel];
  assign rd_valid   = rx_ready && (bytes_left(int'(cnt_rd), int'(rd_idx)) != 0);
  assign clr_hit    = clr_ready && rx_ready;
  assign rd_step    = rd_en && rd_valid;
  assign other_full = full[~rd_sel];

  always_comb begin
    full_c = full;
    if (clr_hit) full_c[rd_sel] = 1'b0;
    rsel_c = (clr_hit && other_full) ? ~rd_sel : rd_sel;
    full_n = full_c;
    if (done) full_n[fill_sel] = 1'b1;
    rsel_n = done ? pick_read_sel(full_c[rsel_c], rsel_c, fill_sel) : rsel_c;
  end

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank_ctl
      assign bank_start[b]  = start_ok && (fill_sel == 1'(b));
      assign bank_commit[b] = done && (fill_sel == 1'(b));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= '0;
      fill_sel  <= 1'b0;
      rd_sel    <= 1'b0;
      rd_idx    <= '0;
      accepting <= 1'b0;
      refusing  <= 1'b0;
      ack       <= 1'b0;
      nak       <= 1'b0;
    end else begin
      full     <= full_n;
      rd_sel   <= rsel_n;
      if (done) fill_sel <= ~fill_sel;
      if (clr_hit || rsel_n != rd_sel) rd_idx <= '0;
      else if (rd_step)                rd_idx <= rd_idx + CW'(1);
      ack <= pkt_end && pkt_good && accepting;
      nak <= pkt_end && pkt_good && refusing;
      if (pkt_start) begin
        accepting <= !both_full;
        refusing  <= both_full;
      end else if (pkt_end) begin
        accepting <= 1'b0;
        refusing  <= 1'b0;
      end
    end
  end

  // R2: an ACK follows only a good end of an accepted packet
  assert_ack_after_good_end_R2: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(pkt_end && pkt_good));
  // R3: a NAK follows only a good end of a refused packet
  assert_nak_after_good_end_R3: assert property (@(posedge clk) disable iff (rst)
    nak |-> $past(pkt_end && pkt_good) && !ack);
  // R4: a bad end answers nothing
  assert_bad_end_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (pkt_end && !pkt_good) |=> (!ack && !nak));
  // R5: clearing with the other buffer full keeps the ready flag
  assert_clear_keeps_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && other_full) |=> rx_ready);
  // R8: a request implies a packet at the read side
  assert_dma_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rx_ready);
  // R9: reading with nothing ready leaves the position unchanged
  assert_empty_read_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rx_ready && !done) |=> $stable(rd_idx));
endmodule

// File: rtl/pp_rx_top.sv
module pp_rx_top #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pkt_start,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pkt_end,
  input  logic          pkt_good,
  output logic          ack,
  output logic          nak,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_ready,
  input  logic          clr_ready,
  output logic          dma_req
);
  logic          fill_sel, rd_sel, accepting, rd_valid;
  logic [CW-1:0] rd_idx;
  logic [1:0]    bank_start, bank_commit;
  logic [CW-1:0] cnt   [2];
  logic [DW-1:0] rdata [2];

  pp_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .pkt_good(pkt_good), .rd_en(rd_en), .clr_ready(clr_ready),
    .cnt0(cnt[0]), .cnt1(cnt[1]), .fill_sel(fill_sel), .rd_sel(rd_sel),
    .rd_idx(rd_idx), .accepting(accepting), .bank_start(bank_start),
    .bank_commit(bank_commit), .ack(ack), .nak(nak), .rx_ready(rx_ready),
    .rd_valid(rd_valid)
  );

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      pp_rx_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
        .clk(clk), .rst(rst), .start(bank_start[b]),
        .we(wr_en && accepting && fill_sel == 1'(b)),
        .wdata(wr_data), .commit(bank_commit[b]), .raddr(rd_idx),
        .rdata(rdata[b]), .cnt(cnt[b])
      );
    end
  endgenerate

  assign rd_data  = rd_valid ? rdata[rd_sel] : '0;
  assign rx_count = rx_ready ? cnt[rd_sel] : '0;
  assign dma_req  = rd_valid;
endmodule

// File: tb/sim_pp_rx_top.sv
module sim_pp_rx_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic pkt_start = 0, wr_en = 0, pkt_end = 0, pkt_good = 0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 0, clr_ready = 0;
  logic ack, nak, rx_ready, dma_req;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rx_count;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_rx_top #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .wr_en(wr_en),
    .wr_data(wr_data), .pkt_end(pkt_end), .pkt_good(pkt_good), .ack(ack),
    .nak(nak), .rd_en(rd_en), .rd_data(rd_data), .rx_count(rx_count),
    .rx_ready(rx_ready), .clr_ready(clr_ready), .dma_req(dma_req)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic begin_pkt();
    @(negedge clk) pkt_start = 1;
    @(negedge clk) pkt_start = 0;
  endtask

  task automatic put_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wr_en = 1; wr_data = DW'(base + i);
    end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic end_pkt(input bit good, input int eack, input int enak, input string tag);
    @(negedge clk) pkt_end = 1; pkt_good = good;
    @(negedge clk) pkt_end = 0; pkt_good = 0;
    chk(ack, eack, {tag, " ack"});
    chk(nak, enak, {tag, " nak"});
  endtask

  task automatic send(input int n, input int base, input bit good,
                      input int eack, input int enak, input string tag);
    begin_pkt();
    put_bytes(n, base);
    end_pkt(good, eack, enak, tag);
  endtask

  // Read n bytes expecting base+i; checks dma_req before each byte.
  task automatic read_bytes(input int n, input int base, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rd_data, (base + i) & 8'hFF, {tag, " byte"});
      chk(dma_req, 1, {tag, " R8 dma while data"});
      rd_en = 1;
      @(negedge clk) rd_en = 0;
    end
  endtask

  task automatic clear_ready();
    @(negedge clk) clr_ready = 1;
    @(negedge clk) clr_ready = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rx_ready, 0, "R1 ready"); chk(rx_count, 0, "R1 count");
    chk(dma_req, 0, "R1 dma"); chk(ack, 0, "R1 ack");
    chk(nak, 0, "R1 nak"); chk(rd_data, 0, "R1 data");
  endtask

  task automatic t_empty_read();
    @(negedge clk) rd_en = 1; clr_ready = 1;
    @(negedge clk) rd_en = 0; clr_ready = 0;
    chk(rd_data, 0, "R9 empty data"); chk(rx_ready, 0, "R9 empty ready");
    chk(dma_req, 0, "R9 empty dma");
  endtask

  task automatic t_basic();
    send(5, 'h10, 1, 1, 0, "R2 basic");
    chk(rx_ready, 1, "R2 ready"); chk(rx_count, 5, "R2 count");
    read_bytes(5, 'h10, "R7 basic");
    chk(dma_req, 0, "R8 dma drop"); chk(rx_ready, 1, "R8 ready held");
    @(negedge clk) rd_en = 1;
    @(negedge clk) rd_en = 0;
    chk(rd_data, 0, "R9 past end data"); chk(rx_count, 5, "R9 past end count");
    clear_ready();
    chk(rx_ready, 0, "R6 clear drops ready");
  endtask

  task automatic t_bad();
    send(3, 'h33, 0, 0, 0, "R4 bad");
    chk(rx_ready, 0, "R4 no ready");
    send(2, 'h50, 1, 1, 0, "R4 after bad");
    chk(rx_count, 2, "R4 buffer free count");
    read_bytes(2, 'h50, "R4 data");
    clear_ready();
  endtask

  task automatic t_both_full();
    send(4, 'h20, 1, 1, 0, "R2 A");
    send(6, 'h40, 1, 1, 0, "R2 B");
    send(3, 'h60, 1, 0, 1, "R3 C");
    chk(rx_count, 4, "R3 head count"); chk(rd_data, 'h20, "R3 head data");
    read_bytes(4, 'h20, "R7 A");
    clear_ready();
    chk(rx_ready, 1, "R5 ready kept"); chk(rx_count, 6, "R5 count B");
    chk(rd_data, 'h40, "R5 data B");
    send(2, 'h90, 1, 1, 0, "R11 F accepted");
    read_bytes(6, 'h40, "R11 B order");
    clear_ready();
    chk(rx_ready, 1, "R11 ready for F"); chk(rx_count, 2, "R11 count F");
    read_bytes(2, 'h90, "R11 F data");
    clear_ready();
    chk(rx_ready, 0, "R11 all drained");
  endtask

  task automatic t_wait_case();
    send(2, 'h70, 1, 1, 0, "R2 D");
    begin_pkt();
    put_bytes(1, 'h80);
    read_bytes(2, 'h70, "R7 D");
    clear_ready();
    chk(rx_ready, 0, "R6 waiting"); chk(dma_req, 0, "R6 no dma");
    put_bytes(2, 'h81);
    end_pkt(1, 1, 0, "R6 E");
    chk(rx_ready, 1, "R6 ready E"); chk(rx_count, 3, "R6 count E");
    read_bytes(3, 'h80, "R6 E data");
    clear_ready();
  endtask

  task automatic t_overflow();
    send(70, 0, 1, 1, 0, "R10 long");
    chk(rx_count, DEPTH, "R10 count sat");
    read_bytes(DEPTH, 0, "R10 data");
    chk(dma_req, 0, "R10 dma drop");
    clear_ready();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_empty_read();
    t_basic();
    t_bad();
    t_both_full();
    t_wait_case();
    t_overflow();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule